// File: doc/BRIEF.md
# Reference-Timed Pixel Stream Aligner

The block lines up two pixel streams that describe the same picture but arrive at different times. The earlier stream, with its five control signals (line start, line end, frame start, frame end, valid), is written into a circular pixel memory. The memory address of the first pixel of each of its lines goes into a small queue of line start addresses. The later stream is the reference. Each time it starts a line, the block takes the oldest queued address and reads that line back, one pixel for every reference valid cycle. The frame's first line is read from a one-entry frame start store.

The reference pixel and its controls leave the block after a fixed delay of `LAT` cycles. That delay equals the latency of the memory read path, so the delayed earlier stream and the reference stream share one set of output controls. The block can absorb a lag of up to `MAX_LINES` line starts. When more are pending than that, the oldest queued line is lost, and a sticky overflow flag is raised and kept until reset.

The pixel memory has 2^(`MAX_LINES` + ceil(log2(`LINE_SIZE`))) entries, so a line size that is not a power of two is rounded up. The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `ref_stream_aligner`

## Requirements
- R1: `out_ref_pix` and the output controls (`out_sol`, `out_eol`, `out_sof`, `out_eof`, `out_vld`) equal `ref_pix` and the reference controls exactly `LAT` cycles earlier.
- R2: When `out_vld` is high, `out_pix` is the earlier-stream pixel at the same position: the k-th valid pixel after the reference line start, in the line whose start was recorded oldest-first.
- R3: When `out_vld` is low, `out_pix` is zero.
- R4: Earlier-stream cycles with `in_vld` low are not stored. Pixel values present during its blanking never appear at `out_pix`, and they do not shift the alignment.
- R5: A lag of exactly `MAX_LINES` lines gives correct alignment, including after the pixel memory pointer wraps, and does not raise `overflow`.
- R6: An earlier-stream line start that arrives while `MAX_LINES` line starts are pending, in a cycle with no reference line start, sets `overflow`. `overflow` then stays high until reset.
- R7: While reset is asserted, and right after it, every output is zero, including `overflow`.
- R8: A lag of a single cycle between the two streams is aligned correctly.
- R9: A reference frame start line reads from the address recorded at the earlier stream's frame start. In an overflow-free run, that address equals the oldest queued line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_pix | input | PIX_W | Earlier stream pixel |
| in_sol | input | 1 | Earlier stream line start |
| in_eol | input | 1 | Earlier stream line end |
| in_sof | input | 1 | Earlier stream frame start |
| in_eof | input | 1 | Earlier stream frame end |
| in_vld | input | 1 | Earlier stream pixel valid |
| ref_pix | input | PIX_W | Reference stream pixel |
| ref_sol | input | 1 | Reference line start |
| ref_eol | input | 1 | Reference line end |
| ref_sof | input | 1 | Reference frame start |
| ref_eof | input | 1 | Reference frame end |
| ref_vld | input | 1 | Reference pixel valid |
| out_pix | output | PIX_W | Earlier stream pixel aligned to the reference |
| out_ref_pix | output | PIX_W | Delayed reference pixel |
| out_sol | output | 1 | Shared output line start |
| out_eol | output | 1 | Shared output line end |
| out_sof | output | 1 | Shared output frame start |
| out_eof | output | 1 | Shared output frame end |
| out_vld | output | 1 | Shared output valid |
| overflow | output | 1 | Sticky flag: line start queue overrun |

## Verification
The bench drives the same frame shape on both streams, at lags from one cycle up to `MAX_LINES` lines and beyond. In some runs the earlier stream carries nonzero pixel values during blanking. A design that stored blanking cycles would slip by several pixels on every line. A single-cycle lag catches a queue whose new entry is not yet visible when the reference pops it; that design would read a stale or wrong line. A lag of exactly `MAX_LINES` lines catches an overflow flag that fires one entry too early. Running that case over several frames also wraps the memory pointer, which exposes a wrong wrap width. A lag one line too long must raise the flag, and the flag must stay high until reset clears it.

// File: rtl/psa_pkg.sv
package psa_pkg;
  // Control bundle carried with every pixel.
  typedef struct packed {
    logic sol;
    logic eol;
    logic sof;
    logic eof;
    logic vld;
  } pctl_t;

  localparam int CTL_W = 5;
endpackage

// File: rtl/psa_delay.sv
module psa_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] stg_q [DEPTH];
      logic [W-1:0] stg_d [DEPTH];

      always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
        end else begin
          for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
        end
      end

      assign q = stg_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/psa_ring.sv
module psa_ring #(
  parameter int PIX_W = 8,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PIX_W-1:0] wr_data,
  output logic [AW-1:0]    wr_ptr,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [PIX_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d;
  logic [PIX_W-1:0] rdat_q, rdat_d;

  always_comb begin
    wptr_d = wptr_q;
    if (wr_en) wptr_d = wptr_q + 1'b1;
  end

  always_comb begin
    rdat_d = '0;
    if (rd_en) rdat_d = mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rdat_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rdat_q <= rdat_d;
    end
  end

  assign wr_ptr  = wptr_q;
  assign rd_data = rdat_q;

  // R4
  wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wptr_q));
endmodule

// File: rtl/psa_lsfifo.sv
module psa_lsfifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] head,
  output logic          nonempty,
  output logic          drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] ent [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign do_pop   = pop && nonempty;
  assign drop     = push && full && !do_pop;
  assign head     = ent[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = ptr_inc(wp_q);
    if (do_pop || drop) rp_d = ptr_inc(rp_q);
    if (push && !drop && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !push)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) ent[wp_q] <= push_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // R6
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/ref_stream_aligner.sv
module ref_stream_aligner #(
  parameter int PIX_W     = 8,
  parameter int MAX_LINES = 4,
  parameter int LINE_SIZE = 16,
  parameter int LAT       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_sol,
  input  logic             in_eol,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_vld,
  input  logic [PIX_W-1:0] ref_pix,
  input  logic             ref_sol,
  input  logic             ref_eol,
  input  logic             ref_sof,
  input  logic             ref_eof,
  input  logic             ref_vld,
  output logic [PIX_W-1:0] out_pix,
  output logic [PIX_W-1:0] out_ref_pix,
  output logic             out_sol,
  output logic             out_eol,
  output logic             out_sof,
  output logic             out_eof,
  output logic             out_vld,
  output logic             overflow
);
  import psa_pkg::*;

  localparam int LB  = $clog2(LINE_SIZE);
  localparam int AW  = MAX_LINES + LB;
  localparam int RDW = PIX_W + CTL_W;

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  pctl_t in_ctl, ref_ctl, dly_ctl;
  assign in_ctl  = '{sol: in_sol,  eol: in_eol,  sof: in_sof,  eof: in_eof,  vld: in_vld};
  assign ref_ctl = '{sol: ref_sol, eol: ref_eol, sof: ref_sof, eof: ref_eof, vld: ref_vld};

  logic          push, ref_start, drop, q_nonempty;
  logic [AW-1:0] wr_ptr, q_head, rd_addr;
  logic [AW-1:0] rdp_q, rdp_d, frm_q, frm_d;
  logic          ovf_q, ovf_d;
  logic [PIX_W-1:0] rd_data, dly_pix;
  logic [RDW-1:0]   ref_bus_q;

  assign push      = in_ctl.vld && in_ctl.sol;
  assign ref_start = ref_ctl.vld && ref_ctl.sol;

  always_comb begin
    rd_addr = rdp_q;
    if (ref_start) rd_addr = ref_ctl.sof ? frm_q : q_head;
  end

  always_comb begin
    rdp_d = rdp_q;
    if (ref_ctl.vld) rdp_d = rd_addr + 1'b1;
    frm_d = frm_q;
    if (in_ctl.vld && in_ctl.sof) frm_d = wr_ptr;
    ovf_d = ovf_q || drop;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rdp_q <= '0;
      frm_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      rdp_q <= rdp_d;
      frm_q <= frm_d;
      ovf_q <= ovf_d;
    end
  end

  psa_ring #(.PIX_W(PIX_W), .AW(AW)) u_ring (
    .clk    (clk),
    .rst_n  (rst_ns),
    .wr_en  (in_ctl.vld),
    .wr_data(in_pix),
    .wr_ptr (wr_ptr),
    .rd_en  (ref_ctl.vld),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  psa_lsfifo #(.DEPTH(MAX_LINES), .AW(AW)) u_lines (
    .clk      (clk),
    .rst_n    (rst_ns),
    .push     (push),
    .push_addr(wr_ptr),
    .pop      (ref_start),
    .head     (q_head),
    .nonempty (q_nonempty),
    .drop     (drop)
  );

  // Reference path: LAT stages, matching one read register plus LAT-1 stages.
  psa_delay #(.W(RDW), .DEPTH(LAT)) u_ref_dly (
    .clk  (clk),
    .rst_n(rst_ns),
    .d    ({ref_pix, ref_ctl}),
    .q    (ref_bus_q)
  );

  psa_delay #(.W(PIX_W), .DEPTH(LAT - 1)) u_pix_dly (
    .clk  (clk),
    .rst_n(rst_ns),
    .d    (rd_data),
    .q    (dly_pix)
  );

  assign dly_ctl     = ref_bus_q[CTL_W-1:0];
  assign out_ref_pix = ref_bus_q[RDW-1:CTL_W];
  assign out_sol     = dly_ctl.sol;
  assign out_eol     = dly_ctl.eol;
  assign out_sof     = dly_ctl.sof;
  assign out_eof     = dly_ctl.eof;
  assign out_vld     = dly_ctl.vld;
  assign out_pix     = dly_pix;
  assign overflow    = ovf_q;

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    overflow |=> overflow);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    drop |=> overflow);

  // R3
  zero_pix_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !out_vld |-> (out_pix == '0));

  // R9
  frame_addr_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (ref_start && ref_ctl.sof && q_nonempty && !ovf_q) |-> (frm_q == q_head));
endmodule

// File: tb/sim_ref_stream_aligner.sv
module sim_ref_stream_aligner;
  localparam int CLK_P = 10;
  localparam int PW  = 8;
  localparam int ML  = 4;
  localparam int LS  = 16;
  localparam int LAT = 10;
  localparam int FW  = 12;
  localparam int P   = 16;
  localparam int NL  = 6;
  localparam int F   = NL * P + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] in_pix = '0, ref_pix = '0;
  logic in_sol = 0, in_eol = 0, in_sof = 0, in_eof = 0, in_vld = 0;
  logic ref_sol = 0, ref_eol = 0, ref_sof = 0, ref_eof = 0, ref_vld = 0;
  logic [PW-1:0] out_pix, out_ref_pix;
  logic out_sol, out_eol, out_sof, out_eof, out_vld, overflow;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  ref_stream_aligner #(.PIX_W(PW), .MAX_LINES(ML), .LINE_SIZE(LS), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_pix(in_pix), .in_sol(in_sol), .in_eol(in_eol), .in_sof(in_sof), .in_eof(in_eof), .in_vld(in_vld),
    .ref_pix(ref_pix), .ref_sol(ref_sol), .ref_eol(ref_eol), .ref_sof(ref_sof), .ref_eof(ref_eof), .ref_vld(ref_vld),
    .out_pix(out_pix), .out_ref_pix(out_ref_pix),
    .out_sol(out_sol), .out_eol(out_eol), .out_sof(out_sof), .out_eof(out_eof), .out_vld(out_vld),
    .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Control bundle {sol,eol,sof,eof,vld} for stream time t.
  function automatic logic [4:0] gen(input int t, input int nfr);
    int ft, ln, col;
    logic v, s, e;
    if (t < 0 || t >= nfr * F) return 5'b0;
    ft  = t % F;
    ln  = ft / P;
    col = ft % P;
    v = (ln < NL) && (col < FW);
    s = v && (col == 0);
    e = v && (col == FW - 1);
    return {s, e, s && (ln == 0), e && (ln == NL - 1), v};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {in_sol, in_eol, in_sof, in_eof, in_vld} = '0;
    {ref_sol, ref_eol, ref_sof, ref_eof, ref_vld} = '0;
    in_pix = '0; ref_pix = '0;
    repeat (3) @(negedge clk);
    // R7: outputs cleared during reset
    chk("R7", {out_sol, out_eol, out_sof, out_eof, out_vld}, 0);
    chk("R7", int'(out_pix) + int'(out_ref_pix), 0);
    chk("R7", int'(overflow), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7", int'(overflow) + int'(out_vld) + int'(out_pix), 0);
  endtask

  task automatic run_test(input int lag, input int nfr, input bit gappy,
                          input bit chk_data, input string tag);
    int store [int];
    int lsq [$];
    int wcnt = 0;
    int rc = 0;
    bit ovf_m = 0;
    int e_rpix [64];
    int e_ctl [64];
    int e_opix [64];
    bit e_dok [64];
    logic [4:0] ci, cr;
    int total;
    for (int i = 0; i < 64; i++) begin
      e_rpix[i] = 0; e_ctl[i] = 0; e_opix[i] = 0; e_dok[i] = 1'b0;
    end
    do_reset();
    total = nfr * F + lag + LAT + 4;
    for (int n = 0; n < total; n++) begin
      // compare outputs produced by inputs of cycle n-LAT
      if (n >= LAT) begin
        int k = (n - LAT) % 64;
        chk("R1", int'(out_ref_pix), e_rpix[k]);
        chk("R1", int'({out_sol, out_eol, out_sof, out_eof, out_vld}), e_ctl[k]);
        if (e_ctl[k][0] == 1'b0) chk("R3", int'(out_pix), 0);
        else if (chk_data && e_dok[k]) chk(tag, int'(out_pix), e_opix[k]);
      end
      // R6: sticky overflow flag, one cycle behind the model
      chk((tag == "R5") ? "R5" : "R6", int'(overflow), int'(ovf_m));

      // drive cycle n
      ci = gen(n, nfr);
      cr = gen(n - lag, nfr);
      {in_sol, in_eol, in_sof, in_eof, in_vld} = ci;
      {ref_sol, ref_eol, ref_sof, ref_eof, ref_vld} = cr;
      if (ci[0]) in_pix = PW'(n * 13 + 5);
      else       in_pix = gappy ? PW'((n * 29 + 1) | 1) : '0;
      if (cr[0]) ref_pix = PW'(n * 7 + 100);
      else       ref_pix = gappy ? PW'(8'hAA) : '0;

      // behavioural model
      begin
        int k = n % 64;
        e_rpix[k] = int'(ref_pix);
        e_ctl[k]  = int'(cr);
        e_opix[k] = 0;
        e_dok[k]  = 1'b0;
        if (cr[0] && cr[4] && lsq.size() > 0) rc = lsq.pop_front();
        if (cr[0]) begin
          if (store.exists(rc)) begin
            e_opix[k] = store[rc];
            e_dok[k]  = 1'b1;
          end
          rc++;
        end
        if (ci[0] && ci[4]) begin
          if (lsq.size() == ML) begin
            ovf_m = 1'b1;
            void'(lsq.pop_front());
          end
          lsq.push_back(wcnt);
        end
        if (ci[0]) begin
          store[wcnt] = int'(in_pix);
          wcnt++;
        end
      end
      @(negedge clk);
    end
    // final overflow state after the run
    chk((tag == "R5") ? "R5" : "R6", int'(overflow), int'(ovf_m));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    run_test(2 * P + 5, 2, 1'b0, 1'b1, "R2");   // R2 basic alignment
    run_test(3 * P + 9, 2, 1'b1, 1'b1, "R4");   // R4 blanking pixels ignored
    run_test(1,         2, 1'b1, 1'b1, "R8");   // R8 one-cycle lag
    run_test(ML * P,    4, 1'b0, 1'b1, "R5");   // R5 full-depth lag, pointer wrap; R9 frame starts
    run_test(ML * P + P + 2, 2, 1'b0, 1'b0, "R6"); // R6 overflow raised and held
    do_reset();                                 // R6 flag cleared only by reset
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule